// File: doc/BRIEF.md
# SPI-to-parallel NAND flash bridge

This block is a serial slave that gives a host access to a raw 8-bit NAND flash device through a handful of SPI-style pins. Each transaction opens when chip select goes low. The first byte on the serial line is an opcode, and the opcode decides how the bytes that follow are framed and what they do. Depending on the opcode, the block loads its configuration register, pushes bytes onto the NAND data bus behind write strobes, or pulses the read strobe and returns the captured bytes on the serial output.

The configuration register drives the NAND chip enable, command latch and address latch pins directly. It also drives a fan enable and four active-low LED outputs. The host therefore selects command, address or data cycles by rewriting this register, and only then streams bytes.

All serial pins are brought into the system clock domain through two-flop synchronizers. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x8F. This gives nand_ce_n=1, nand_cle=0, nand_ale=0, fan_on=0 and led_n=4'hF. Also nand_we_n=1, nand_re_n=1, nand_dq_oe=0 and miso=0.
- R2: After opcode 0x09, every byte that follows loads the configuration register. Bytes are single-line, MSB first, sampled on the rising sck edge. The bit mapping is: bit 7 to nand_ce_n, bit 6 to nand_cle, bit 5 to nand_ale, bit 4 to fan_on, and bits 3..0 to led_n[3:0].
- R3: After opcode 0x08, each byte is carried two bits per sck rise, so a byte takes four rises. The higher bit of each pair is on mosi and the lower bit on mosi2, and the pairs arrive from bits 7:6 down to 1:0.
- R4: In a 0x08 transaction, the byte of slot k is written to NAND when slot k+1 completes. The byte of the last slot before chip select rises is never written. Each write is exactly one nand_we_n low pulse of at least STROBE_CLKS clocks. nand_dq_oe is high and nand_dq_out is stable one clock before the pulse falls and in the clock after it rises.
- R5: In a 0x08 transaction, miso presents bits 7,6,5,4 of the previous slot's byte during the four rises of the current slot. During the first slot it presents zeros.
- R6: Opcode 0x0A is followed by one idle slot and then data slots. Data slot j returns, single-line and MSB first, the j-th byte read from NAND in that transaction. A transaction with N data slots issues N+1 read strobes, because one byte is always prefetched.
- R7: Opcode 0x0B behaves like 0x0A but with FAST_IDLE (default 4) idle slots before the first data slot.
- R8: Raising chip select ends the transaction. Any partial byte and any pending write byte are discarded, and the next byte after chip select falls is decoded as an opcode.
- R9: Any other opcode causes the rest of the transaction to be ignored: no NAND strobe, and no change to the configuration register.
- R10: nand_we_n and nand_re_n are never low together. A read strobe only occurs in a read transaction and a write strobe only occurs in a 0x08 transaction.
- R11: miso is 0 during the opcode slot and during every idle slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host, idles low |
| csn | input | 1 | Serial chip select, active low |
| mosi | input | 1 | Primary serial data input |
| mosi2 | input | 1 | Second data line, used by dual-line write |
| miso | output | 1 | Serial data output to host |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_dq_out | output | 8 | NAND data bus, driven value |
| nand_dq_oe | output | 1 | NAND data bus output enable |
| nand_dq_in | input | 8 | NAND data bus, sampled value |
| fan_on | output | 1 | Fan enable |
| led_n | output | 4 | Four LED drives, active low |

## Verification
The hardest situation to reach is the deferred write commit. The last byte clocked into a write transaction must be echoed but never reach the NAND bus, and an abort in the middle of a stream must drop exactly one pending byte. The bench runs write transactions of several lengths and one aborted after three slots. For each, it compares the bench-side log of nand_we_n pulses against the bytes sent, and compares the nibble echo against the previous slot's byte. It also sweeps every configuration value and every undefined opcode, and it tracks the NAND read pointer to confirm the single-byte prefetch.

// File: rtl/spi_nand_pkg.sv
package spi_nand_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h08;
  localparam logic [7:0] OPC_CFG   = 8'h09;
  localparam logic [7:0] OPC_READ  = 8'h0A;
  localparam logic [7:0] OPC_FREAD = 8'h0B;

  typedef enum logic [2:0] {
    PH_OPC, PH_WRITE, PH_CFG, PH_IDLE, PH_READ, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HOLD
  } strobe_st_t;

  typedef struct packed {
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic       fan;
    logic [3:0] led_n;
  } cfg_t;
endpackage

// File: rtl/spi_nand_sync.sv
module spi_nand_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_nand_shift.sv
module spi_nand_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              d0_s,
  input  logic              d1_s,
  input  logic              dual,
  output logic              rise,
  output logic              slot_start,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_d;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt;
  logic              last;

  assign rise       = sck_s & ~sck_d & ~csn_s;
  assign slot_start = rise & (cnt == '0);
  assign last       = dual ? (cnt == CNT_W'(BYTE_W/2 - 1)) : (cnt == CNT_W'(BYTE_W - 1));
  assign nxt        = dual ? {shreg[BYTE_W-3:0], d0_s, d1_s} : {shreg[BYTE_W-2:0], d0_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d     <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else begin
      sck_d     <= sck_s;
      byte_done <= 1'b0;
      if (csn_s) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= nxt;
        if (last) begin
          cnt       <= '0;
          byte_done <= 1'b1;
          byte_q    <= nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8
  csn_clears_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !byte_done);
endmodule

// File: rtl/spi_nand_strobe.sv
module spi_nand_strobe
  import spi_nand_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_req,
  input  logic       rd_req,
  input  logic [7:0] wr_data,
  input  logic [7:0] dq_in,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic [7:0] rd_data
);
  localparam int CW = $clog2(STROBE_CLKS + 1);

  strobe_st_t    st;
  logic [CW-1:0] cnt;
  logic          is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      is_rd   <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (wr_req) begin
            dq_out <= wr_data;
            dq_oe  <= 1'b1;
            is_rd  <= 1'b0;
            st     <= ST_SETUP;
          end else if (rd_req) begin
            is_rd <= 1'b1;
            st    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt <= '0;
          if (is_rd) re_n <= 1'b0;
          else       we_n <= 1'b0;
          st <= ST_LOW;
        end
        ST_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(STROBE_CLKS - 1)) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_rd) rd_data <= dq_in;
            st <= ST_HOLD;
          end
        end
        default: begin
          dq_oe <= 1'b0;
          st    <= ST_IDLE;
        end
      endcase
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_req));
  // R4
  req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req || rd_req) |-> (st == ST_IDLE));
  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (dq_oe && $past(dq_oe)));
  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (dq_oe && $stable(dq_out)));
  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |=> !we_n);
  // R6
  re_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(re_n) |=> !re_n);
endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
  import spi_nand_pkg::*;
#(
  parameter int          STROBE_CLKS = 3,
  parameter int          FAST_IDLE   = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CFG_RESET   = 8'h8F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       csn,
  input  logic       mosi,
  input  logic       mosi2,
  output logic       miso,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic [7:0] nand_dq_out,
  output logic       nand_dq_oe,
  input  logic [7:0] nand_dq_in,
  output logic       fan_on,
  output logic [3:0] led_n
);
  localparam int IW = $clog2(FAST_IDLE + 1);

  logic [3:0] pins_s;
  logic       sck_s, csn_s, d0_s, d1_s;
  logic       rise, slot_start, byte_done;
  logic [7:0] byte_q;

  phase_t     phase_q;
  logic [IW-1:0] idle_left;
  logic [7:0] pend;
  logic       have_pend;
  logic [7:0] tx_q;
  logic [7:0] cfg_q;
  logic       wr_go, rd_go;
  logic [7:0] wr_byte;
  logic [7:0] rd_data;
  cfg_t       cfg_v;

  spi_nand_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck, csn, mosi, mosi2}),
    .q   (pins_s)
  );
  assign {sck_s, csn_s, d0_s, d1_s} = pins_s;

  spi_nand_shift #(.BYTE_W(8)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (sck_s),
    .csn_s      (csn_s),
    .d0_s       (d0_s),
    .d1_s       (d1_s),
    .dual       (phase_q == PH_WRITE),
    .rise       (rise),
    .slot_start (slot_start),
    .byte_done  (byte_done),
    .byte_q     (byte_q)
  );

  spi_nand_strobe #(.STROBE_CLKS(STROBE_CLKS)) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_go),
    .rd_req  (rd_go),
    .wr_data (wr_byte),
    .dq_in   (nand_dq_in),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .dq_out  (nand_dq_out),
    .dq_oe   (nand_dq_oe),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_OPC;
      idle_left <= '0;
      pend      <= '0;
      have_pend <= 1'b0;
      tx_q      <= '0;
      cfg_q     <= CFG_RESET;
      wr_go     <= 1'b0;
      rd_go     <= 1'b0;
      wr_byte   <= '0;
    end else begin
      wr_go <= 1'b0;
      rd_go <= 1'b0;
      if (csn_s) begin
        phase_q   <= PH_OPC;
        have_pend <= 1'b0;
        tx_q      <= '0;
      end else if (byte_done) begin
        case (phase_q)
          PH_OPC: begin
            tx_q <= '0;
            case (byte_q)
              OPC_WRITE: begin
                phase_q   <= PH_WRITE;
                have_pend <= 1'b0;
              end
              OPC_CFG:   phase_q <= PH_CFG;
              OPC_READ: begin
                phase_q   <= PH_IDLE;
                idle_left <= IW'(1);
                rd_go     <= 1'b1;
              end
              OPC_FREAD: begin
                phase_q   <= PH_IDLE;
                idle_left <= IW'(FAST_IDLE);
                rd_go     <= (FAST_IDLE == 1);
              end
              default:   phase_q <= PH_SKIP;
            endcase
          end
          PH_WRITE: begin
            if (have_pend) begin
              wr_go   <= 1'b1;
              wr_byte <= pend;
            end
            pend      <= byte_q;
            have_pend <= 1'b1;
            tx_q      <= byte_q;
          end
          PH_CFG: cfg_q <= byte_q;
          PH_IDLE: begin
            if (idle_left == IW'(1)) begin
              phase_q <= PH_READ;
              tx_q    <= rd_data;
            end else begin
              idle_left <= idle_left - 1'b1;
              if (idle_left == IW'(2)) rd_go <= 1'b1;
            end
          end
          PH_READ: tx_q <= rd_data;
          default: ;
        endcase
      end else if (rise) begin
        tx_q <= {tx_q[6:0], 1'b0};
        if (slot_start && phase_q == PH_READ) rd_go <= 1'b1;
      end
    end
  end

  assign cfg_v     = cfg_t'(cfg_q);
  assign nand_ce_n = cfg_v.ce_n;
  assign nand_cle  = cfg_v.cle;
  assign nand_ale  = cfg_v.ale;
  assign fan_on    = cfg_v.fan;
  assign led_n     = cfg_v.led_n;
  assign miso      = tx_q[7];

  // R10
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> (phase_q == PH_WRITE));
  // R10
  rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> (phase_q == PH_IDLE || phase_q == PH_READ));
  // R9
  cfg_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> ($past(phase_q) == PH_CFG));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE || phase_q == PH_OPC) |-> !miso);
endmodule

// File: tb/spi_nand_bridge_tb.sv
module spi_nand_bridge_tb;
  localparam int STROBE = 3;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, mosi2 = 1'b0;
  logic miso, ce_n, cle, ale, we_n, re_n, dq_oe, fan;
  logic [7:0] dq_out, dq_in;
  logic [3:0] led_n;

  int checks = 0, fails = 0;
  int wcount = 0, rptr = 0, lowcnt = 0, short_pulses = 0, overlap = 0;
  int cyc = 0;
  logic [7:0] wlog [64];

  always #2 clk = ~clk;

  spi_nand_bridge #(.STROBE_CLKS(STROBE)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .mosi2(mosi2),
    .miso(miso), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_out(dq_out),
    .nand_dq_oe(dq_oe), .nand_dq_in(dq_in), .fan_on(fan), .led_n(led_n)
  );

  function automatic logic [7:0] mem_at(int i);
    return 8'((i * 29 + 3) & 255);
  endfunction

  function automatic logic [7:0] wpat(int n, int i);
    return 8'((i * 37 + n * 11 + 5) & 255);
  endfunction

  assign dq_in = mem_at(rptr);

  always @(posedge re_n) if (!rst) rptr++;
  always @(posedge we_n) if (!rst) begin
    if (wcount < 64) wlog[wcount] = dq_out;
    wcount++;
  end
  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (!we_n && !re_n) overlap++;
      if (!we_n || !re_n) lowcnt++;
      else begin
        if (lowcnt != 0 && lowcnt < STROBE) short_pulses++;
        lowcnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b0, input logic b1, output logic m);
    mosi = b0; mosi2 = b1;
    repeat (HALF) @(negedge clk);
    m = miso;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xs(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) put_bit(b[i], 1'b0, r[i]);
  endtask

  task automatic xd(input logic [7:0] b, output logic [3:0] r);
    for (int k = 0; k < 4; k++) put_bit(b[7-2*k], b[6-2*k], r[3-k]);
  endtask

  task automatic cs_on();
    @(negedge clk); csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  function automatic logic [7:0] cfg_now();
    return {ce_n, cle, ale, fan, led_n};
  endfunction

  task automatic set_cfg(input logic [7:0] v);
    logic [7:0] r;
    cs_on(); xs(8'h09, r); xs(v, r); cs_off();
  endtask

  task automatic do_write(input int n, input int abort_after);
    logic [7:0] r;
    logic [3:0] e;
    int w0, slots;
    w0 = wcount;
    slots = (abort_after > 0) ? abort_after : n;
    cs_on(); xs(8'h08, r);
    for (int i = 0; i < slots; i++) begin
      xd(wpat(n, i), e);
      // R5 echo of previous byte's upper nibble
      check(e == ((i == 0) ? 4'h0 : wpat(n, i-1)[7:4]), "R5", e,
            (i == 0) ? 0 : wpat(n, i-1)[7:4]);
    end
    if (abort_after == 0) begin
      xd(8'h00, e);
      check(e == wpat(n, n-1)[7:4], "R5", e, wpat(n, n-1)[7:4]);
    end
    cs_off();
    // R4 count: the final slot's byte is never committed; R8 abort drops pending
    check(wcount - w0 == slots - ((abort_after > 0) ? 1 : 0),
          (abort_after > 0) ? "R8" : "R4", wcount - w0,
          slots - ((abort_after > 0) ? 1 : 0));
    for (int i = 0; i < wcount - w0; i++)
      // R3 dual-line byte assembly
      check(wlog[w0+i] == wpat(n, i), "R3", wlog[w0+i], wpat(n, i));
  endtask

  task automatic do_read(input logic [7:0] opc, input int idles, input int n);
    logic [7:0] r;
    int p;
    p = rptr;
    cs_on(); xs(opc, r);
    for (int i = 0; i < idles; i++) begin
      xs(8'hFF, r);
      // R11
      check(r == 8'h00, "R11", r, 0);
    end
    for (int j = 0; j < n; j++) begin
      xs(8'h00, r);
      check(r == mem_at(p + j), (opc == 8'h0B) ? "R7" : "R6", r, mem_at(p + j));
    end
    cs_off();
    // R6 one prefetch
    check(rptr == p + n + 1, "R6", rptr, p + n + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int w0, p0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1
    check(cfg_now() == 8'h8F, "R1", cfg_now(), 8'h8F);
    check({we_n, re_n, dq_oe, miso} == 4'b1100, "R1", {we_n, re_n, dq_oe, miso}, 4'b1100);

    // R2 sweep every configuration value in one transaction
    cs_on(); xs(8'h09, r);
    for (int v = 0; v < 256; v++) begin
      xs(8'(v), r);
      repeat (2) @(negedge clk);
      check(cfg_now() == 8'(v), "R2", cfg_now(), v);
    end
    cs_off();
    check(cfg_now() == 8'hFF, "R2", cfg_now(), 8'hFF);

    // R3 R4 R5 writes of several lengths
    do_write(1, 0);
    do_write(3, 0);
    do_write(8, 0);
    // R8 abort after three slots then a fresh opcode
    do_write(5, 3);
    set_cfg(8'h5A);
    check(cfg_now() == 8'h5A, "R8", cfg_now(), 8'h5A);

    // R6 R7 reads
    do_read(8'h0A, 1, 1);
    do_read(8'h0A, 1, 4);
    do_read(8'h0A, 1, 16);
    do_read(8'h0B, 4, 5);

    // R9 sweep of undefined opcodes
    set_cfg(8'h8F);
    for (int o = 0; o < 256; o++) begin
      if (o >= 8 && o <= 11) continue;
      w0 = wcount; p0 = rptr;
      cs_on(); xs(8'(o), r); xs(8'h00, r); cs_off();
      check(cfg_now() == 8'h8F && wcount == w0 && rptr == p0, "R9",
            {cfg_now(), 8'(wcount - w0), 8'(rptr - p0)}, 24'h8F0000);
    end

    // R10 strobes never overlapped; R4 pulse widths
    check(overlap == 0, "R10", overlap, 0);
    check(short_pulses == 0, "R4", short_pulses, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule